// File: doc/BRIEF.md
# Dual-Mode Serial Interrupt Flag Controller

This block holds the interrupt status and enable state for a serial port that runs either as a UART or as an SPI master or slave. The serial datapath sends it single-cycle event pulses: transmit data moved into the shifter, receive buffer loaded, and parity, framing and overrun errors. The block records each event in a flag of the active mode's bank. It masks each flag with its own enable bit and drives one level interrupt request toward the system interrupt controller.

Software uses a small register port. One write port sets the mode, clears flags by writing 1 and loads enables. One combinational read port returns the mode, the flags or the enables. A three-state-plus-off mode machine selects which bank is live. Writing code 0 to the mode field is a software reset. It is the only way to remove an overrun condition.

Mode machine states:
- `ST_OFF`: code 0, no bank is active.
- `ST_UART`: code 1.
- `ST_SPI_MST`: code 2.
- `ST_SPI_SLV`: code 3.

Transitions:
- Every transition is a mode write at address 0 carrying code 0, 1, 2 or 3, and it goes to the matching state from any state.
- A write of code 4 to 7 keeps the current state.

Top module: `ser_irq_flags`

## Requirements
- R1: After reset, the mode reads 0 (off), all flags and enables read 0, and `irq` is low.
- R2: A write to address 0 with `reg_wdata[2:0]` of 0, 1, 2 or 3 selects off, UART, SPI master or SPI slave, and the code reads back at address 0. Codes 4 to 7 are ignored.
- R3: A receive-load event sets the receive-full flag in both modes: UART flag bit 0, SPI flag bit 1. The flag clears on a write of 1 to that bit at address 1, or on an `rxbuf_read` pulse.
- R4: In SPI modes, a transmit-moved event sets flag bit 0. The bit clears on a write of 1 to it or on a `txbuf_write` pulse. In UART mode the transmit-moved event is ignored.
- R5: In UART mode, parity, framing and overrun events set flag bits 1, 2 and 3. Bits 1 and 2 clear on a write of 1. The single UART error enable (enable bit 1) covers all three; enable bit 0 is receive-full.
- R6: The overrun indication is sticky: UART flag bit 3, and SPI flag bit 2, which is set by the overrun event. A write of 1 has no effect on it. Only a mode write removes it.
- R7: `irq` is the OR of (flag AND enable) over the active mode's causes. It is high in the first cycle the flag reads 1. SPI enables are bit 0 transmit-empty, bit 1 receive-full and bit 2 error, written and read at address 2.
- R8: When a set event and a clear (write of 1 or auto-clear) land in the same cycle, the flag ends up set.
- R9: A valid mode write (code 0 to 3) clears every flag of both banks, and events in that cycle are dropped. Code 0 also clears both enable banks. Other codes keep each bank's enables across mode switches.
- R10: While off, events, flag writes and enable writes have no effect, flags read 0 and `irq` stays low. In SPI modes, parity and framing events are ignored.
- R11: A flag records its event even while its enable is 0, and `irq` stays low for that cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write address: 0 mode, 1 flag clear, 2 enables |
| reg_wdata | input | 8 | Write data |
| reg_raddr | input | 2 | Read address: 0 mode, 1 flags, 2 enables, 3 reads 0 |
| reg_rdata | output | 8 | Read data for `reg_raddr` |
| ev_tx_moved | input | 1 | Transmit data moved into the shift register |
| ev_rx_loaded | input | 1 | Received data loaded into the receive buffer |
| ev_parity_err | input | 1 | Parity error detected |
| ev_frame_err | input | 1 | Framing error detected |
| ev_overrun | input | 1 | Overrun error detected |
| rxbuf_read | input | 1 | Receive data buffer read (auto-clears receive-full) |
| txbuf_write | input | 1 | Transmit data buffer written (auto-clears transmit-empty) |
| irq | output | 1 | Interrupt request to the interrupt controller |

## Verification
The assertions check on every cycle that:
- the overrun and SPI error flags survive any cycle without a mode write;
- a set event always leaves its flag set, even against a clear;
- an inactive bank's flags are zero, and `irq` never rises while off;
- a code-0 write wipes both enable banks;
- a code of 4 to 7 keeps the state.

Only the bench's scenarios can show the other behaviours:
- the exact read-back layout of each mode;
- enables being kept per bank across a UART-to-SPI-to-UART round trip;
- events in a mode-write cycle being dropped;
- `irq` following flag AND enable over long mixed stimulus.

// File: rtl/ser_irq_pkg.sv
package ser_irq_pkg;

    localparam int MODE_W   = 3;
    localparam int UFLAG_N  = 4;
    localparam int UEN_N    = 2;
    localparam int SFLAG_N  = 3;
    localparam int SEN_N    = 3;

    localparam logic [1:0] A_MODE  = 2'd0;
    localparam logic [1:0] A_FLAGS = 2'd1;
    localparam logic [1:0] A_EN    = 2'd2;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_UART    = 2'd1,
        ST_SPI_MST = 2'd2,
        ST_SPI_SLV = 2'd3
    } mode_st_e;

endpackage

// File: rtl/ser_irq_fsm.sv
module ser_irq_fsm
    import ser_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_code_in,
    output logic              uart_act,
    output logic              spi_act,
    output logic [MODE_W-1:0] mode_code
);

    mode_st_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (mode_wr) begin
            unique case (mode_code_in)
                3'd0:    state_d = ST_OFF;
                3'd1:    state_d = ST_UART;
                3'd2:    state_d = ST_SPI_MST;
                3'd3:    state_d = ST_SPI_SLV;
                default: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        uart_act  = 1'b0;
        spi_act   = 1'b0;
        mode_code = '0;
        unique case (state_q)
            ST_OFF:     mode_code = 3'd0;
            ST_UART:    begin uart_act = 1'b1; mode_code = 3'd1; end
            ST_SPI_MST: begin spi_act  = 1'b1; mode_code = 3'd2; end
            ST_SPI_SLV: begin spi_act  = 1'b1; mode_code = 3'd3; end
            default:    mode_code = 3'd0;
        endcase
    end

    AST_BAD_CODE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_code_in > 3'd3) |=> $stable(state_q)); // R2

endmodule

// File: rtl/ser_irq_uart_bank.sv
module ser_irq_uart_bank
    import ser_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic               clr_all,
    input  logic               en_clr,
    input  logic               ev_rx,
    input  logic               ev_par,
    input  logic               ev_frm,
    input  logic               ev_ovr,
    input  logic               rd_clr,
    input  logic [UFLAG_N-1:0] w1c,
    input  logic               en_we,
    input  logic [UEN_N-1:0]   en_wdata,
    output logic [UFLAG_N-1:0] flags,
    output logic [UEN_N-1:0]   en,
    output logic               irq
);

    logic [UFLAG_N-1:0] set_v, clr_v, flag_d;

    always_comb begin
        set_v = {ev_ovr, ev_frm, ev_par, ev_rx};
        clr_v = {1'b0, w1c[2], w1c[1], w1c[0] | rd_clr};
        if (clr_all || !active) flag_d = '0;
        else                    flag_d = set_v | (flags & ~clr_v);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
            en    <= '0;
        end else begin
            flags <= flag_d;
            if (en_clr)     en <= '0;
            else if (en_we) en <= en_wdata;
        end
    end

    assign irq = active & ((flags[0] & en[0]) | ((|flags[3:1]) & en[1]));

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[3] && active && !clr_all) |=> flags[3]); // R6
    AST_PAR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_par && active && !clr_all) |=> flags[1]); // R8
    AST_UART_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!active) |=> (flags == '0)); // R10

endmodule

// File: rtl/ser_irq_spi_bank.sv
module ser_irq_spi_bank
    import ser_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic               clr_all,
    input  logic               en_clr,
    input  logic               ev_tx,
    input  logic               ev_rx,
    input  logic               ev_err,
    input  logic               rd_clr,
    input  logic               wr_clr,
    input  logic [SFLAG_N-1:0] w1c,
    input  logic               en_we,
    input  logic [SEN_N-1:0]   en_wdata,
    output logic [SFLAG_N-1:0] flags,
    output logic [SEN_N-1:0]   en,
    output logic               irq
);

    logic [SFLAG_N-1:0] set_v, clr_v, flag_d;

    always_comb begin
        set_v = {ev_err, ev_rx, ev_tx};
        clr_v = {1'b0, w1c[1] | rd_clr, w1c[0] | wr_clr};
        if (clr_all || !active) flag_d = '0;
        else                    flag_d = set_v | (flags & ~clr_v);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
            en    <= '0;
        end else begin
            flags <= flag_d;
            if (en_clr)     en <= '0;
            else if (en_we) en <= en_wdata;
        end
    end

    assign irq = active & (|(flags & en));

    AST_SPI_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[2] && active && !clr_all) |=> flags[2]); // R6
    AST_SPI_RX_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx && active && !clr_all) |=> flags[1]); // R3
    AST_SPI_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!active) |=> (flags == '0)); // R10

endmodule

// File: rtl/ser_irq_flags.sv
module ser_irq_flags
    import ser_irq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [ADDR_W-1:0] reg_raddr,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ev_tx_moved,
    input  logic              ev_rx_loaded,
    input  logic              ev_parity_err,
    input  logic              ev_frame_err,
    input  logic              ev_overrun,
    input  logic              rxbuf_read,
    input  logic              txbuf_write,
    output logic              irq
);

    logic              mode_wr, clr_all, en_clr, flag_wr, en_wr;
    logic              uart_act, spi_act, uart_irq, spi_irq;
    logic [MODE_W-1:0] mode_code, code_in;
    logic [UFLAG_N-1:0] uflags;
    logic [UEN_N-1:0]   uen;
    logic [SFLAG_N-1:0] sflags;
    logic [SEN_N-1:0]   sen;
    logic [UFLAG_N-1:0] w1c_v;
    logic               unused_wdata;

    assign code_in      = reg_wdata[MODE_W-1:0];
    assign mode_wr      = reg_we && (reg_addr == A_MODE);
    assign clr_all      = mode_wr && (code_in <= 3'd3);
    assign en_clr       = clr_all && (code_in == 3'd0);
    assign flag_wr      = reg_we && (reg_addr == A_FLAGS);
    assign en_wr        = reg_we && (reg_addr == A_EN);
    assign w1c_v        = flag_wr ? reg_wdata[UFLAG_N-1:0] : '0;
    assign unused_wdata = ^reg_wdata[DATA_W-1:UFLAG_N];

    ser_irq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_code_in(code_in),
        .uart_act(uart_act), .spi_act(spi_act), .mode_code(mode_code)
    );

    ser_irq_uart_bank u_uart (
        .clk(clk), .rst_n(rst_n), .active(uart_act), .clr_all(clr_all),
        .en_clr(en_clr), .ev_rx(ev_rx_loaded), .ev_par(ev_parity_err),
        .ev_frm(ev_frame_err), .ev_ovr(ev_overrun), .rd_clr(rxbuf_read),
        .w1c(w1c_v), .en_we(en_wr && uart_act),
        .en_wdata(reg_wdata[UEN_N-1:0]), .flags(uflags), .en(uen), .irq(uart_irq)
    );

    ser_irq_spi_bank u_spi (
        .clk(clk), .rst_n(rst_n), .active(spi_act), .clr_all(clr_all),
        .en_clr(en_clr), .ev_tx(ev_tx_moved), .ev_rx(ev_rx_loaded),
        .ev_err(ev_overrun), .rd_clr(rxbuf_read), .wr_clr(txbuf_write),
        .w1c(w1c_v[SFLAG_N-1:0]), .en_we(en_wr && spi_act),
        .en_wdata(reg_wdata[SEN_N-1:0]), .flags(sflags), .en(sen), .irq(spi_irq)
    );

    assign irq = uart_irq | spi_irq;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_raddr)
            A_MODE:  reg_rdata = {{(DATA_W-MODE_W){1'b0}}, mode_code};
            A_FLAGS: begin
                if (uart_act)     reg_rdata = {{(DATA_W-UFLAG_N){1'b0}}, uflags};
                else if (spi_act) reg_rdata = {{(DATA_W-SFLAG_N){1'b0}}, sflags};
            end
            A_EN: begin
                if (uart_act)     reg_rdata = {{(DATA_W-UEN_N){1'b0}}, uen};
                else if (spi_act) reg_rdata = {{(DATA_W-SEN_N){1'b0}}, sen};
            end
            default: reg_rdata = '0;
        endcase
    end

    AST_EN_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr |=> (uen == '0 && sen == '0)); // R9
    AST_OFF_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 3'd0) |-> !irq); // R10

endmodule

// File: tb/ser_irq_flags_test.sv
module ser_irq_flags_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [1:0] reg_raddr = '0;
    logic [7:0] reg_rdata;
    logic       ev_tx_moved = 1'b0, ev_rx_loaded = 1'b0, ev_parity_err = 1'b0;
    logic       ev_frame_err = 1'b0, ev_overrun = 1'b0;
    logic       rxbuf_read = 1'b0, txbuf_write = 1'b0;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    int rcnt = 0;
    bit done = 0;
    string tag = "R1";

    int m_mode = 0;
    bit [3:0] m_uf = '0;
    bit [1:0] m_ue = '0;
    bit [2:0] m_sf = '0;
    bit [2:0] m_se = '0;

    always #10 clk = ~clk;

    ser_irq_flags uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .ev_tx_moved(ev_tx_moved), .ev_rx_loaded(ev_rx_loaded),
        .ev_parity_err(ev_parity_err), .ev_frame_err(ev_frame_err),
        .ev_overrun(ev_overrun), .rxbuf_read(rxbuf_read),
        .txbuf_write(txbuf_write), .irq(irq)
    );

    // Behavioural reference model
    always @(posedge clk) begin
        bit [7:0] w1c;
        w1c = (reg_we && reg_addr == 2'd1) ? reg_wdata : 8'h00;
        if (!rst_n) begin
            m_mode = 0; m_uf = '0; m_ue = '0; m_sf = '0; m_se = '0;
        end else if (reg_we && reg_addr == 2'd0 && reg_wdata[2:0] <= 3) begin
            m_mode = int'(reg_wdata[2:0]);
            m_uf = '0; m_sf = '0;
            if (reg_wdata[2:0] == 0) begin m_ue = '0; m_se = '0; end
        end else if (m_mode == 1) begin
            m_uf[0] = ev_rx_loaded  | (m_uf[0] & !(w1c[0] | rxbuf_read));
            m_uf[1] = ev_parity_err | (m_uf[1] & !w1c[1]);
            m_uf[2] = ev_frame_err  | (m_uf[2] & !w1c[2]);
            m_uf[3] = ev_overrun    | m_uf[3];
            if (reg_we && reg_addr == 2'd2) m_ue = reg_wdata[1:0];
        end else if (m_mode == 2 || m_mode == 3) begin
            m_sf[0] = ev_tx_moved  | (m_sf[0] & !(w1c[0] | txbuf_write));
            m_sf[1] = ev_rx_loaded | (m_sf[1] & !(w1c[1] | rxbuf_read));
            m_sf[2] = ev_overrun   | m_sf[2];
            if (reg_we && reg_addr == 2'd2) m_se = reg_wdata[2:0];
        end
    end

    function automatic bit exp_irq();
        if (m_mode == 1) return (m_uf[0] & m_ue[0]) | ((|m_uf[3:1]) & m_ue[1]);
        if (m_mode >= 2) return |(m_sf & m_se);
        return 1'b0;
    endfunction

    function automatic bit [7:0] exp_rd(input bit [1:0] a);
        case (a)
            2'd0: return 8'(m_mode);
            2'd1: return (m_mode == 1) ? {4'h0, m_uf} : (m_mode >= 2) ? {5'h0, m_sf} : 8'h00;
            2'd2: return (m_mode == 1) ? {6'h0, m_ue} : (m_mode >= 2) ? {5'h0, m_se} : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    task automatic compare();
        n_cmp++;
        if (irq !== exp_irq()) begin
            n_bad++;
            $display("FAIL %s irq actual=%0b expected=%0b t=%0t", tag, irq, exp_irq(), $time);
        end
        n_cmp++;
        if (reg_rdata !== exp_rd(reg_raddr)) begin
            n_bad++;
            $display("FAIL %s rdata[a=%0d] actual=%02h expected=%02h t=%0t",
                     tag, reg_raddr, reg_rdata, exp_rd(reg_raddr), $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        compare();
        reg_we = 0; ev_tx_moved = 0; ev_rx_loaded = 0; ev_parity_err = 0;
        ev_frame_err = 0; ev_overrun = 0; rxbuf_read = 0; txbuf_write = 0;
        rcnt = (rcnt + 1) % 3;
        reg_raddr = 2'(rcnt);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input bit [1:0] a, input bit [7:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        cyc();
    endtask

    initial begin
        tag = "R1";
        idle(3);
        rst_n = 1;
        idle(3);

        tag = "R2"; wr(2'd0, 8'h05); idle(3);
        wr(2'd0, 8'h01); idle(3);

        tag = "R11"; ev_rx_loaded = 1; cyc(); idle(3);
        tag = "R7";  wr(2'd2, 8'h01); idle(3);
        tag = "R3";  rxbuf_read = 1; cyc(); idle(3);
        tag = "R8";  ev_rx_loaded = 1; cyc();
        ev_rx_loaded = 1; reg_we = 1; reg_addr = 2'd1; reg_wdata = 8'h01; cyc(); idle(3);
        tag = "R3";  wr(2'd1, 8'h01); idle(3);
        tag = "R4";  ev_tx_moved = 1; cyc(); idle(3);
        tag = "R5";  wr(2'd2, 8'h00); ev_parity_err = 1; cyc(); ev_frame_err = 1; cyc();
        wr(2'd2, 8'h02); idle(3);
        wr(2'd1, 8'h06); idle(3);
        ev_overrun = 1; cyc(); idle(3);
        tag = "R6";  wr(2'd1, 8'h0F); idle(3);
        tag = "R8";  ev_frame_err = 1; reg_we = 1; reg_addr = 2'd1; reg_wdata = 8'h04; cyc(); idle(3);

        tag = "R9";  wr(2'd0, 8'h02); idle(3);
        tag = "R4";  ev_tx_moved = 1; cyc(); idle(3);
        wr(2'd2, 8'h01); idle(3);
        txbuf_write = 1; cyc(); idle(3);
        ev_tx_moved = 1; cyc(); wr(2'd1, 8'h01); idle(3);
        tag = "R10"; ev_parity_err = 1; ev_frame_err = 1; cyc(); idle(3);
        tag = "R3";  wr(2'd2, 8'h06); ev_rx_loaded = 1; cyc(); idle(3);
        wr(2'd1, 8'h02); idle(3);
        tag = "R6";  ev_overrun = 1; cyc(); wr(2'd1, 8'h07); idle(3);

        tag = "R9";  wr(2'd0, 8'h01); idle(3);
        wr(2'd0, 8'h03); idle(3);
        ev_rx_loaded = 1; reg_we = 1; reg_addr = 2'd0; reg_wdata = 8'h03; cyc(); idle(3);
        wr(2'd0, 8'h00); idle(3);
        tag = "R10"; ev_rx_loaded = 1; ev_overrun = 1; ev_tx_moved = 1; cyc();
        wr(2'd2, 8'h03); wr(2'd1, 8'h0F); idle(3);

        tag = "R7";
        for (int i = 0; i < 600; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            ev_tx_moved   = ($urandom_range(0, 3) == 0);
            ev_rx_loaded  = ($urandom_range(0, 3) == 0);
            ev_parity_err = ($urandom_range(0, 7) == 0);
            ev_frame_err  = ($urandom_range(0, 7) == 0);
            ev_overrun    = ($urandom_range(0, 15) == 0);
            rxbuf_read    = ($urandom_range(0, 3) == 0);
            txbuf_write   = ($urandom_range(0, 3) == 0);
            if (r < 5) begin
                reg_we = 1; reg_addr = 2'd0; reg_wdata = 8'($urandom_range(0, 7));
            end else if (r < 30) begin
                reg_we = 1; reg_addr = 2'd1; reg_wdata = 8'($urandom_range(0, 15));
            end else if (r < 45) begin
                reg_we = 1; reg_addr = 2'd2; reg_wdata = 8'($urandom_range(0, 7));
            end
            cyc();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete (actual=hung expected=done)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule